// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block is a register-mapped management master for the two-wire PHY management bus (MDC/MDIO, Clause 22 frames). It derives the management clock MDC from the system clock through a programmable divider and serialises one read or one write frame at a time to an external PHY on a bidirectional data pin. The pin is presented as three signals: an output value, an output enable and an input value.

Software talks to the block through a small synchronous register port with three word registers: a version register, a control register and an access register. The control register holds the engine enable bit, a read-only idle flag and the divider. The access register holds the command, the PHY and register addresses and the data. A host launches a frame by writing the access register with its launch bit set. It then polls the same register until the launch bit clears, and reads the acknowledge flag and the data there. Reads of the register port return data one clock after the address is presented.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control register reads idle=1 (bit 31), enable=0 (bit 30) and the divider field (bits 15:0) equal to the DEF_DIV parameter. The access register reads all zero, MDC is low and the data output enable is low.
- R2: Word address 0 reads the version register: major revision in bits 15:8, minor revision in bits 7:0, all other bits zero. Address 1 is the control register and address 2 is the access register.
- R3: While a frame runs, the MDC period is divider+1 system clocks for divider values of 1 or more; a divider of 0 behaves as 1, giving a period of 2 clocks. Between frames MDC stays low.
- R4: Every frame starts with 32 driven one bits. The next 14 bits, MSB first, are the start code 01, the opcode (10 = read, 01 = write), the 5-bit PHY address and the 5-bit register address. The access register's fields for these are bit 30 (1 = write), bits 20:16 (PHY) and bits 25:21 (register).
- R5: A write frame keeps the output enabled for all 64 bits and sends turnaround 10 followed by access bits 15:0, MSB first. Once the write completes, ACK (bit 29) reads 0.
- R6: A read frame releases the output for its last 18 bits, from the turnaround onward. When it completes, ACK (bit 29) is 1 exactly when MDIO was sampled low on the rising MDC edge of the second turnaround bit, and bits 15:0 then hold the 16 bits sampled on the following rising edges, MSB first.
- R7: The launch bit GO (bit 31) reads 1 from the launching write until the frame completes and then clears without any host action.
- R8: A write to the access register while GO reads 1 changes nothing in that register, and the frame in flight is unaffected.
- R9: Clearing enable while a frame runs lets that frame finish, after which idle reads 1. A frame launched while enable is 0 stays pending with GO=1 and no MDC activity, and it runs once enable is set again. Idle reads 0 while enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 version, 1 control, 2 access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one clock after reg_addr |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Value driven on the data pin |
| mdio_oe | output | 1 | Output enable of the data pin |
| mdio_i | input | 1 | Value sampled from the data pin |

## Verification
The bench places a PHY model on the pins that answers reads only at some addresses. This makes both acknowledged and unacknowledged reads occur, and a design that set ACK from the wrong turnaround bit, or one bit late, would report the wrong ACK or return data shifted by one bit. The model records every bit the master drives and the enable pattern, so an opcode swap, a short preamble or an early release of the pin shows up as a mismatched frame. Divider values of 0, 1 and larger ones are measured at MDC, which exposes off-by-one errors in the period and a divider of 0 that stalls the clock. The bench also hits the access register while GO is set and toggles enable in the middle of a frame and before a launch: a design that accepted the late write would corrupt the address fields, and one that aborted or started frames while disabled would leave GO stuck or start MDC too early.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_ADDR_W  = 2;
  localparam int REG_DATA_W  = 32;
  localparam int PHY_FIELD_W = 5;
  localparam int MGMT_DATA_W = 16;
  localparam int BODY_BITS   = 32;

  // control register fields
  localparam int CTL_IDLE_BIT = 31;
  localparam int CTL_EN_BIT   = 30;
  // access register fields
  localparam int ACC_GO_BIT   = 31;
  localparam int ACC_WR_BIT   = 30;
  localparam int ACC_ACK_BIT  = 29;
  localparam int ACC_REG_LSB  = 21;
  localparam int ACC_PHY_LSB  = 16;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_VERSION = 2'd0,
    RA_CONTROL = 2'd1,
    RA_ACCESS  = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic                   wr;
    logic [PHY_FIELD_W-1:0] regad;
    logic [PHY_FIELD_W-1:0] phy;
    logic [MGMT_DATA_W-1:0] data;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W:0]   period;
  logic [DIV_W-1:0] hi_len;

  always_comb begin
    div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    period  = {1'b0, div_eff} + {{DIV_W{1'b0}}, 1'b1};
    hi_len  = period[DIV_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      mdc_o  <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (cnt_q == div_eff) begin
        cnt_q  <= '0;
        mdc_o  <= 1'b1;
        rise_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == hi_len - 1'b1 && mdc_o) begin
          mdc_o  <= 1'b0;
          fall_o <= 1'b1;
        end
      end
    end
  end

  // R3: no clock activity outside a frame
  // R3
  mdc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  mgmt_cmd_t              cmd_i,
  input  logic                   rise_i,
  input  logic                   fall_i,
  input  logic                   mdio_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   ack_o,
  output logic [MGMT_DATA_W-1:0] rdata_o,
  output logic                   mdio_o,
  output logic                   mdio_oe_o
);
  localparam int FRAME_LEN = PRE_LEN + BODY_BITS;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA1_IDX   = PRE_LEN + 14;
  localparam int TA2_IDX   = PRE_LEN + 15;
  localparam int DAT_IDX   = PRE_LEN + 16;

  logic [IDX_W-1:0]     idx_q;
  logic [BODY_BITS-1:0] body_q;
  logic                 is_rd_q;
  int                   nxt;
  logic                 nxt_bit;

  always_comb begin
    nxt     = int'(idx_q) + 1;
    nxt_bit = (nxt < PRE_LEN) ? 1'b1 : body_q[5'(BODY_BITS - 1 - (nxt - PRE_LEN))];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      ack_o     <= 1'b0;
      rdata_o   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
      idx_q     <= '0;
      body_q    <= '0;
      is_rd_q   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o    <= 1'b1;
        idx_q     <= '0;
        is_rd_q   <= !cmd_i.wr;
        body_q    <= {2'b01, (cmd_i.wr ? 2'b01 : 2'b10), cmd_i.phy, cmd_i.regad,
                      (cmd_i.wr ? 2'b10 : 2'b11),
                      (cmd_i.wr ? cmd_i.data : {MGMT_DATA_W{1'b1}})};
        mdio_o    <= 1'b1;
        mdio_oe_o <= 1'b1;
        ack_o     <= 1'b0;
        rdata_o   <= '0;
      end else if (busy_o) begin
        if (rise_i && is_rd_q) begin
          if (int'(idx_q) == TA2_IDX) ack_o <= !mdio_i;
          if (int'(idx_q) >= DAT_IDX) rdata_o <= {rdata_o[MGMT_DATA_W-2:0], mdio_i};
        end
        if (fall_i) begin
          if (int'(idx_q) == FRAME_LEN - 1) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b1;
            mdio_oe_o <= 1'b0;
            mdio_o    <= 1'b1;
          end else begin
            idx_q     <= idx_q + 1'b1;
            mdio_o    <= nxt_bit;
            mdio_oe_o <= !(is_rd_q && nxt >= TA1_IDX);
          end
        end
      end
    end
  end

  // R6: the pin is released from the turnaround onward on reads
  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && is_rd_q && int'(idx_q) >= TA1_IDX) |-> !mdio_oe_o);

  // R5: writes keep driving while the frame runs
  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !is_rd_q) |-> mdio_oe_o);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int          DIV_W     = 16,
  parameter int          PRE_LEN   = 32,
  parameter logic [15:0] DEF_DIV   = 16'd9,
  parameter logic [7:0]  VER_MAJOR = 8'd2,
  parameter logic [7:0]  VER_MINOR = 8'd5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  input  logic                  mdio_i
);
  logic                   en_q;
  logic [DIV_W-1:0]       div_q;
  logic                   go_q;
  logic                   ack_q;
  mgmt_cmd_t              cmd_q;
  logic                   eng_start, eng_busy, eng_done, eng_ack;
  logic [MGMT_DATA_W-1:0] eng_rdata;
  logic                   mdc_rise, mdc_fall;
  logic                   acc_wr, ctl_wr, idle;

  assign acc_wr    = reg_wr_en && (reg_addr == RA_ACCESS);
  assign ctl_wr    = reg_wr_en && (reg_addr == RA_CONTROL);
  assign eng_start = go_q && en_q && !eng_busy && !eng_done;
  assign idle      = !en_q && !eng_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= DIV_W'(DEF_DIV);
      go_q  <= 1'b0;
      ack_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (ctl_wr) begin
        en_q  <= reg_wdata[CTL_EN_BIT];
        div_q <= reg_wdata[DIV_W-1:0];
      end
      if (eng_done) begin
        go_q  <= 1'b0;
        ack_q <= eng_ack;
        if (!cmd_q.wr) cmd_q.data <= eng_rdata;
      end else if (acc_wr && !go_q) begin
        go_q        <= reg_wdata[ACC_GO_BIT];
        ack_q       <= 1'b0;
        cmd_q.wr    <= reg_wdata[ACC_WR_BIT];
        cmd_q.regad <= reg_wdata[ACC_REG_LSB +: PHY_FIELD_W];
        cmd_q.phy   <= reg_wdata[ACC_PHY_LSB +: PHY_FIELD_W];
        cmd_q.data  <= reg_wdata[MGMT_DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        RA_VERSION: reg_rdata[15:0] <= {VER_MAJOR, VER_MINOR};
        RA_CONTROL: begin
          reg_rdata[CTL_IDLE_BIT]  <= idle;
          reg_rdata[CTL_EN_BIT]    <= en_q;
          reg_rdata[DIV_W-1:0]     <= div_q;
        end
        RA_ACCESS: begin
          reg_rdata[ACC_GO_BIT]                        <= go_q;
          reg_rdata[ACC_WR_BIT]                        <= cmd_q.wr;
          reg_rdata[ACC_ACK_BIT]                       <= ack_q;
          reg_rdata[ACC_REG_LSB +: PHY_FIELD_W]        <= cmd_q.regad;
          reg_rdata[ACC_PHY_LSB +: PHY_FIELD_W]        <= cmd_q.phy;
          reg_rdata[MGMT_DATA_W-1:0]                   <= cmd_q.data;
        end
        default: reg_rdata <= '0;
      endcase
    end
  end

  mdio_mgmt_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk    (clk),
    .rst    (rst),
    .run_i  (eng_busy),
    .div_i  (div_q),
    .mdc_o  (mdc),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mdio_mgmt_engine #(.PRE_LEN(PRE_LEN)) engine_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (eng_start),
    .cmd_i     (cmd_q),
    .rise_i    (mdc_rise),
    .fall_i    (mdc_fall),
    .mdio_i    (mdio_i),
    .busy_o    (eng_busy),
    .done_o    (eng_done),
    .ack_o     (eng_ack),
    .rdata_o   (eng_rdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe)
  );

  // R7
  go_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(go_q) |-> $past(eng_done));

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (go_q && acc_wr && !eng_done) |=> ($stable(cmd_q) && go_q));

  // R9
  start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(en_q));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  localparam logic [15:0] DEF_DIV = 16'd9;
  localparam logic [7:0]  VMAJ    = 8'd2;
  localparam logic [7:0]  VMIN    = 8'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.DEF_DIV(DEF_DIV), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // ---------------- PHY model ----------------
  logic        phy_drv = 1'b0;
  logic        phy_val = 1'b1;
  logic        in_frame = 1'b0;
  int          pcnt = 0;
  int          frames_seen = 0;
  logic [63:0] cap = '0;
  logic [63:0] oe_hist = '0;
  realtime     t_prev = 0;
  int          last_period = 0;

  assign mdio_i = phy_drv ? phy_val : 1'b1;

  function automatic bit phy_present(input logic [4:0] a);
    return (a != 5'd3) && (a != 5'd20);
  endfunction

  function automatic logic [15:0] phy_resp(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h15} ^ 16'hA5C3;
  endfunction

  always @(posedge mdc) begin
    if (!in_frame && mdio_oe) begin
      in_frame = 1'b1;
      pcnt = 0;
    end
    if (in_frame) begin
      if (pcnt == 1) last_period = int'(($realtime - t_prev) / 4.0);
      t_prev = $realtime;
      cap[63-pcnt]     = mdio_oe ? mdio_o : 1'b0;
      oe_hist[63-pcnt] = mdio_oe;
      pcnt++;
      if (pcnt == 64) begin
        in_frame = 1'b0;
        frames_seen++;
      end
    end
  end

  always @(negedge mdc) begin
    phy_drv = 1'b0;
    if (in_frame && pcnt >= 47 && cap[29:28] == 2'b10 && phy_present(cap[27:23])) begin
      phy_drv = 1'b1;
      if (pcnt == 47) phy_val = 1'b0;
      else phy_val = phy_resp(cap[27:23], cap[22:18])[15-(pcnt-48)];
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_go_clear(output logic [31:0] v);
    for (int i = 0; i < 4000; i++) begin
      rd_reg(2'd2, v);
      if (!v[31]) break;
    end
  endtask

  function automatic logic [31:0] acc_word(input bit wr, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    return {1'b1, wr, 1'b0, 3'b000, r, p, d};
  endfunction

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
  endfunction

  task automatic run_frame(input bit wr, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input int div, input bit poke);
    logic [31:0] v;
    logic [63:0] ef;
    int          seen0;
    int          eper;
    seen0 = frames_seen;
    wr_reg(2'd1, {1'b0, 1'b1, 14'd0, 16'(div)});
    wr_reg(2'd2, acc_word(wr, p, r, d));
    rd_reg(2'd2, v);
    chk(v[31] == 1'b1, "R7 GO set while frame pending", 64'(v[31]), 64'd1);
    if (poke) begin
      wr_reg(2'd2, {1'b1, ~wr, 1'b0, 3'b000, ~r, ~p, ~d});
      rd_reg(2'd2, v);
      chk(v[30:0] == {wr, 1'b0, 3'b000, r, p, d}, "R8 access write ignored while GO",
          64'(v), 64'({1'b1, wr, 1'b0, 3'b000, r, p, d}));
    end
    wait_go_clear(v);
    chk(v[31] == 1'b0 && frames_seen == seen0 + 1, "R7 GO self-clears after one frame",
        64'(frames_seen - seen0), 64'd1);
    ef = exp_frame(wr, p, r, d);
    eper = (div == 0) ? 2 : div + 1;
    chk(last_period == eper, "R3 MDC period", 64'(last_period), 64'(eper));
    if (wr) begin
      chk(cap == ef, "R4/R5 write frame bits", cap, ef);
      chk(oe_hist == '1, "R5 write drives all bits", oe_hist, '1);
      chk(v[29] == 1'b0, "R5 write ACK reads 0", 64'(v[29]), 64'd0);
    end else begin
      chk(cap[63:18] == ef[63:18], "R4 read frame header bits", 64'(cap[63:18]), 64'(ef[63:18]));
      chk(oe_hist == {46'h3FFF_FFFF_FFFF, 18'd0}, "R6 read releases pin at turnaround",
          oe_hist, {46'h3FFF_FFFF_FFFF, 18'd0});
      chk(v[29] == phy_present(p), "R6 read ACK", 64'(v[29]), 64'(phy_present(p)));
      if (phy_present(p))
        chk(v[15:0] == phy_resp(p, r), "R6 read data", 64'(v[15:0]), 64'(phy_resp(p, r)));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] v;
    int          seen0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_reg(2'd1, v);
    chk(v == {1'b1, 1'b0, 14'd0, DEF_DIV}, "R1 control reset", 64'(v), 64'({1'b1, 15'd0, DEF_DIV}));
    rd_reg(2'd2, v);
    chk(v == 32'd0, "R1 access reset", 64'(v), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins quiet", 64'({mdc, mdio_oe}), 64'd0);
    // R2 version
    rd_reg(2'd0, v);
    chk(v == {16'd0, VMAJ, VMIN}, "R2 version", 64'(v), 64'({16'd0, VMAJ, VMIN}));

    // directed frames
    run_frame(1'b1, 5'd1, 5'd4, 16'hBEEF, 3, 1'b1);
    run_frame(1'b0, 5'd1, 5'd4, 16'h0000, 3, 1'b1);
    run_frame(1'b0, 5'd3, 5'd2, 16'h0000, 1, 1'b0);   // absent PHY, no ACK
    run_frame(1'b0, 5'd31, 5'd31, 16'h0000, 0, 1'b0); // divider 0
    run_frame(1'b1, 5'd0, 5'd0, 16'h0001, 5, 1'b0);

    // R9 idle reads 0 while enabled
    rd_reg(2'd1, v);
    chk(v[31] == 1'b0 && v[30] == 1'b1, "R9 idle 0 while enabled", 64'(v[31:30]), 64'd1);

    // random frames
    for (int k = 0; k < 12; k++) begin
      run_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                int'($urandom % 6) + 1, 1'($urandom));
    end

    // R9 disable mid-frame: frame completes, idle returns
    seen0 = frames_seen;
    wr_reg(2'd1, {1'b0, 1'b1, 14'd0, 16'd2});
    wr_reg(2'd2, acc_word(1'b1, 5'd9, 5'd17, 16'h5A5A));
    repeat (20) @(negedge clk);
    wr_reg(2'd1, {1'b0, 1'b0, 14'd0, 16'd2});
    wait_go_clear(v);
    chk(frames_seen == seen0 + 1 && cap == exp_frame(1'b1, 5'd9, 5'd17, 16'h5A5A),
        "R9 frame finishes after disable", cap, exp_frame(1'b1, 5'd9, 5'd17, 16'h5A5A));
    rd_reg(2'd1, v);
    chk(v[31] == 1'b1, "R9 idle after disable", 64'(v[31]), 64'd1);

    // R9 launch while disabled stays pending
    seen0 = frames_seen;
    wr_reg(2'd2, acc_word(1'b0, 5'd6, 5'd1, 16'h0));
    repeat (300) @(negedge clk);
    rd_reg(2'd2, v);
    chk(v[31] == 1'b1 && frames_seen == seen0 && mdc == 1'b0, "R9 pending while disabled",
        64'({v[31], 8'(frames_seen - seen0)}), 64'({1'b1, 8'd0}));
    wr_reg(2'd1, {1'b0, 1'b1, 14'd0, 16'd2});
    wait_go_clear(v);
    chk(frames_seen == seen0 + 1 && v[29] == 1'b1 && v[15:0] == phy_resp(5'd6, 5'd1),
        "R9 runs after re-enable", 64'(v[15:0]), 64'(phy_resp(5'd6, 5'd1)));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule